// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits between a processor's fetch logic and the interrupt request lines of a chip. It gathers requests into sixteen priority slots, and it picks a winner only when the processor strobes that it is ready to take an interrupt. The winner is the highest-numbered slot whose request is qualified. The block then presents that slot's vector word address, where the handler address is stored, together with the slot number. It also sends the winning slot a one-cycle acknowledge. It keeps the global interrupt enable and the individual enables of the non-maskable group, and it clears them on acceptance so that the same event cannot enter again at once.

There are three classes of slot. Slot 15 is the reset slot. It is never gated, and a chip reset source or an out-of-range execution event pulls it. Slot 14 is the non-maskable group: each of its source flags is gated only by its own enable bit. Slots 13 down to 0 are ordinary maskable requests. Each needs its own enable and the global enable. Two further functions watch the fetch bus. A fetch from the register region starting at address zero raises a pending reset request. A reset vector word that reads all ones, as erased storage does, latches a deepest-sleep request in place of execution.

Top module: `intvec_ctrl`

## Requirements
- R1: After synchronous reset: vec_valid=0, ack=0, gie_q=0, nmi_en_q=0, oor_pend=0, sleep_req=0, vec_slot=15, vec_addr=16'hFFFE.
- R2: The vector outputs and ack change only in the cycle after a clock edge at which accept=1. Without accept, vec_valid, vec_addr and vec_slot hold.
- R3: The winner is the highest-numbered qualified slot. vec_addr = 16'hFFE0 + 2*vec_slot, so slot 15 gives 16'hFFFE and slot 0 gives 16'hFFE0.
- R4: Slot 15 is qualified when any rst_src bit is 1 or oor_pend=1. No enable gates it, and it beats every other slot.
- R5: Slot 14 is qualified when (nmi_src & nmi_en_q) is non-zero, whatever the value of gie_q.
- R6: Slot k (0..13) is qualified only when irq_req[k], irq_en[k] and gie_q are all 1.
- R7: Accepting a winner in slot k makes ack equal 1<<k for exactly one cycle. At all other times ack is 0.
- R8: Accepting a winner in slots 0..13 clears gie_q. This clear overrides a gie_wr in the same cycle. Otherwise gie_wr loads gie_din.
- R9: Accepting slot 14 clears the nmi_en_q bits whose source was pending and enabled, and leaves the other bits (after any nmi_en_wr load) unchanged.
- R10: Accepting slot 15 clears gie_q and nmi_en_q. It also clears oor_pend, unless a new out-of-range fetch arrives in the same cycle.
- R11: fetch_valid=1 with fetch_addr <= 16'h01FF sets oor_pend in the next cycle. A fetch at 16'h0200 or above does not.
- R12: rstvec_valid=1 with rstvec_data=16'hFFFF sets sleep_req, which stays 1 until reset. Any other value leaves it unchanged.
- R13: If accept=1 and no slot is qualified, vec_valid becomes 0, ack stays 0, and vec_addr and vec_slot keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| accept | input | 1 | Processor ready to take an interrupt; arbitration strobe |
| rst_src | input | 4 | Chip reset source lines for slot 15 |
| nmi_src | input | 3 | Non-maskable group source flags for slot 14 |
| nmi_en_wr | input | 1 | Load strobe for the non-maskable enables |
| nmi_en_din | input | 3 | Value loaded into nmi_en_q |
| irq_req | input | 14 | ORed request lines of maskable slots 0..13 |
| irq_en | input | 14 | Individual enables of maskable slots 0..13 |
| gie_wr | input | 1 | Load strobe for the global enable |
| gie_din | input | 1 | Value loaded into gie_q |
| fetch_valid | input | 1 | Instruction fetch address is valid |
| fetch_addr | input | 16 | Instruction fetch byte address |
| rstvec_valid | input | 1 | The reset vector word is on rstvec_data |
| rstvec_data | input | 16 | Fetched reset vector word |
| vec_valid | output | 1 | The last accept found a winner |
| vec_addr | output | 16 | Vector word address of the winner |
| vec_slot | output | 4 | Winning slot number |
| ack | output | 16 | One-cycle one-hot acknowledge to the winning slot |
| gie_q | output | 1 | Global interrupt enable |
| nmi_en_q | output | 3 | Individual enables of the non-maskable sources |
| oor_pend | output | 1 | Out-of-range execution reset request pending |
| sleep_req | output | 1 | Deepest-sleep request after an erased reset vector |

## Verification
The bench sets several classes of request against each other in one accept. Examples are a reset source against a pending non-maskable flag, and a non-maskable flag while the global enable is off. A design that gated slot 14 with the global enable, or let it outrank the reset slot, would acknowledge the wrong line. It also drives a global enable write in the same cycle as a maskable acceptance, where a design with the wrong precedence would leave interrupts enabled inside the handler. It probes the fetch bound at 0x01FF and 0x0200, where an off-by-one compare would miss a reset or raise a false one. It issues accepts with nothing qualified, where a faulty design would clobber the held vector address.

// File: rtl/intvec_pkg.sv
package intvec_pkg;
  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_MASK = 2'd1,
    CLS_NMI  = 2'd2,
    CLS_RST  = 2'd3
  } win_cls_e;
endpackage

// File: rtl/intvec_qual.sv
module intvec_qual #(
  parameter int NUM_SLOTS = 16,
  parameter int NMI_W     = 3,
  localparam int NUM_MASK = NUM_SLOTS - 2
) (
  input  logic                 rst_any,
  input  logic [NMI_W-1:0]     nmi_src,
  input  logic [NMI_W-1:0]     nmi_en,
  input  logic [NUM_MASK-1:0]  irq_req,
  input  logic [NUM_MASK-1:0]  irq_en,
  input  logic                 gie,
  output logic [NUM_SLOTS-1:0] qual
);
  // Top slot: never gated. Next slot: only individual enables.
  assign qual[NUM_SLOTS-1] = rst_any;
  assign qual[NUM_SLOTS-2] = |(nmi_src & nmi_en);

  for (genvar g = 0; g < NUM_MASK; g++) begin : g_mask
    assign qual[g] = irq_req[g] & irq_en[g] & gie;
  end
endmodule

// File: rtl/intvec_prio.sv
module intvec_prio #(
  parameter int NUM_SLOTS = 16,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] qual,
  output logic                 any,
  output logic [SLOT_W-1:0]    idx
);
  // Scan upward so the highest qualified slot is the last to write idx.
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (qual[i]) begin
        any = 1'b1;
        idx = SLOT_W'(i);
      end
    end
  end
endmodule

// File: rtl/intvec_guard.sv
module intvec_guard #(
  parameter int              ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] REG_TOP = 16'h01FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              rstvec_valid,
  input  logic [ADDR_W-1:0] rstvec_data,
  input  logic              oor_clr,
  output logic              oor_pend,
  output logic              sleep_req
);
  logic oor_hit;
  logic erased;

  assign oor_hit = fetch_valid && (fetch_addr <= REG_TOP);
  assign erased  = rstvec_valid && (rstvec_data == {ADDR_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      oor_pend  <= 1'b0;
      sleep_req <= 1'b0;
    end else begin
      if (oor_hit)      oor_pend <= 1'b1;
      else if (oor_clr) oor_pend <= 1'b0;
      if (erased)       sleep_req <= 1'b1;
    end
  end
endmodule

// File: rtl/intvec_ctrl.sv
module intvec_ctrl #(
  parameter int                NUM_SLOTS = 16,
  parameter int                NMI_W     = 3,
  parameter int                RST_W     = 4,
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] VEC_TOP   = 16'hFFFE,
  parameter logic [ADDR_W-1:0] REG_TOP   = 16'h01FF,
  localparam int               SLOT_W    = $clog2(NUM_SLOTS),
  localparam int               NUM_MASK  = NUM_SLOTS - 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 accept,
  input  logic [RST_W-1:0]     rst_src,
  input  logic [NMI_W-1:0]     nmi_src,
  input  logic                 nmi_en_wr,
  input  logic [NMI_W-1:0]     nmi_en_din,
  input  logic [NUM_MASK-1:0]  irq_req,
  input  logic [NUM_MASK-1:0]  irq_en,
  input  logic                 gie_wr,
  input  logic                 gie_din,
  input  logic                 fetch_valid,
  input  logic [ADDR_W-1:0]    fetch_addr,
  input  logic                 rstvec_valid,
  input  logic [ADDR_W-1:0]    rstvec_data,
  output logic                 vec_valid,
  output logic [ADDR_W-1:0]    vec_addr,
  output logic [SLOT_W-1:0]    vec_slot,
  output logic [NUM_SLOTS-1:0] ack,
  output logic                 gie_q,
  output logic [NMI_W-1:0]     nmi_en_q,
  output logic                 oor_pend,
  output logic                 sleep_req
);
  import intvec_pkg::*;

  localparam logic [ADDR_W-1:0] VEC_BOT = VEC_TOP - ADDR_W'(2 * (NUM_SLOTS - 1));
  localparam logic [SLOT_W-1:0] RST_IDX = SLOT_W'(NUM_SLOTS - 1);
  localparam logic [SLOT_W-1:0] NMI_IDX = SLOT_W'(NUM_SLOTS - 2);

  logic [NUM_SLOTS-1:0] qual;
  logic                 win_any;
  logic [SLOT_W-1:0]    win_idx;
  win_cls_e             win_cls;
  logic                 oor_clr;
  logic                 gie_base;
  logic [NMI_W-1:0]     nmi_base;

  intvec_qual #(.NUM_SLOTS(NUM_SLOTS), .NMI_W(NMI_W)) u_qual (
    .rst_any (|rst_src | oor_pend),
    .nmi_src (nmi_src),
    .nmi_en  (nmi_en_q),
    .irq_req (irq_req),
    .irq_en  (irq_en),
    .gie     (gie_q),
    .qual    (qual)
  );

  intvec_prio #(.NUM_SLOTS(NUM_SLOTS)) u_prio (
    .qual (qual),
    .any  (win_any),
    .idx  (win_idx)
  );

  always_comb begin
    if (!win_any)                win_cls = CLS_NONE;
    else if (win_idx == RST_IDX) win_cls = CLS_RST;
    else if (win_idx == NMI_IDX) win_cls = CLS_NMI;
    else                         win_cls = CLS_MASK;
  end

  assign oor_clr  = accept && (win_cls == CLS_RST);
  assign gie_base = gie_wr ? gie_din : gie_q;
  assign nmi_base = nmi_en_wr ? nmi_en_din : nmi_en_q;

  intvec_guard #(.ADDR_W(ADDR_W), .REG_TOP(REG_TOP)) u_guard (
    .clk          (clk),
    .rst          (rst),
    .fetch_valid  (fetch_valid),
    .fetch_addr   (fetch_addr),
    .rstvec_valid (rstvec_valid),
    .rstvec_data  (rstvec_data),
    .oor_clr      (oor_clr),
    .oor_pend     (oor_pend),
    .sleep_req    (sleep_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_valid <= 1'b0;
      vec_addr  <= VEC_TOP;
      vec_slot  <= RST_IDX;
      ack       <= '0;
      gie_q     <= 1'b0;
      nmi_en_q  <= '0;
    end else begin
      ack      <= '0;
      gie_q    <= gie_base;
      nmi_en_q <= nmi_base;
      if (accept) begin
        vec_valid <= win_any;
        if (win_any) begin
          vec_slot <= win_idx;
          vec_addr <= VEC_BOT + ADDR_W'({win_idx, 1'b0});
          ack      <= NUM_SLOTS'(1) << win_idx;
        end
        case (win_cls)
          CLS_MASK: gie_q    <= 1'b0;
          CLS_NMI:  nmi_en_q <= nmi_base & ~(nmi_src & nmi_en_q);
          CLS_RST: begin
            gie_q    <= 1'b0;
            nmi_en_q <= '0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/intvec_chk.sv
module intvec_chk #(
  parameter int                NUM_SLOTS = 16,
  parameter int                NMI_W     = 3,
  parameter int                RST_W     = 4,
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] REG_TOP   = 16'h01FF,
  localparam int               SLOT_W    = $clog2(NUM_SLOTS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 accept,
  input logic [RST_W-1:0]     rst_src,
  input logic [NMI_W-1:0]     nmi_src,
  input logic                 fetch_valid,
  input logic [ADDR_W-1:0]    fetch_addr,
  input logic                 rstvec_valid,
  input logic [ADDR_W-1:0]    rstvec_data,
  input logic                 vec_valid,
  input logic [ADDR_W-1:0]    vec_addr,
  input logic [SLOT_W-1:0]    vec_slot,
  input logic [NUM_SLOTS-1:0] ack,
  input logic                 gie_q,
  input logic [NMI_W-1:0]     nmi_en_q,
  input logic                 oor_pend,
  input logic                 sleep_req
);
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(ack)); // R7
  AST_ACK_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (rst) (|ack) |-> $past(accept)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !accept |=> ($stable(vec_addr) && $stable(vec_slot) && $stable(vec_valid))); // R2
  AST_RESET_WINS: assert property (@(posedge clk) disable iff (rst) (accept && (|rst_src)) |=> ack[NUM_SLOTS-1]); // R4
  AST_NMI_IGNORES_GIE: assert property (@(posedge clk) disable iff (rst) (accept && !gie_q && !(|rst_src) && !oor_pend && (|(nmi_src & nmi_en_q))) |=> ack[NUM_SLOTS-2]); // R5
  AST_MASK_CLEARS_GIE: assert property (@(posedge clk) disable iff (rst) (|ack[NUM_SLOTS-3:0]) |-> !gie_q); // R8
  AST_RST_CLEARS_EN: assert property (@(posedge clk) disable iff (rst) ack[NUM_SLOTS-1] |-> (!gie_q && (nmi_en_q == '0))); // R10
  AST_OOR_SET: assert property (@(posedge clk) disable iff (rst) (fetch_valid && (fetch_addr <= REG_TOP)) |=> oor_pend); // R11
  AST_SLEEP_SET: assert property (@(posedge clk) disable iff (rst) (rstvec_valid && (rstvec_data == {ADDR_W{1'b1}})) |=> sleep_req); // R12
  AST_SLEEP_STICKY: assert property (@(posedge clk) disable iff (rst) sleep_req |=> sleep_req); // R12
endmodule

bind intvec_ctrl intvec_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .NMI_W     (NMI_W),
  .RST_W     (RST_W),
  .ADDR_W    (ADDR_W),
  .REG_TOP   (REG_TOP)
) u_chk (.*);

// File: tb/tb_intvec_ctrl.sv
module tb_intvec_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        accept = 1'b0;
  logic [3:0]  rst_src = '0;
  logic [2:0]  nmi_src = '0;
  logic        nmi_en_wr = 1'b0;
  logic [2:0]  nmi_en_din = '0;
  logic [13:0] irq_req = '0;
  logic [13:0] irq_en = '0;
  logic        gie_wr = 1'b0;
  logic        gie_din = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [15:0] fetch_addr = 16'h8000;
  logic        rstvec_valid = 1'b0;
  logic [15:0] rstvec_data = '0;
  logic        vec_valid;
  logic [15:0] vec_addr;
  logic [3:0]  vec_slot;
  logic [15:0] ack;
  logic        gie_q;
  logic [2:0]  nmi_en_q;
  logic        oor_pend;
  logic        sleep_req;

  intvec_ctrl dut (.*);

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string scene = "R1";

  // Reference model state
  bit        m_vv, m_gie, m_oor, m_sleep;
  bit [15:0] m_addr, m_ack;
  bit [3:0]  m_slot;
  bit [2:0]  m_nmi;

  always @(posedge clk) begin
    int win;
    bit ng;
    bit [2:0] nn;
    if (rst) begin
      m_vv = 0; m_addr = 16'hFFFE; m_slot = 4'd15; m_ack = '0;
      m_gie = 0; m_nmi = '0; m_oor = 0; m_sleep = 0;
    end else begin
      win = -1;
      m_ack = '0;
      ng = gie_wr ? gie_din : m_gie;
      nn = nmi_en_wr ? nmi_en_din : m_nmi;
      if (accept) begin
        if ((rst_src != 0) || m_oor) win = 15;
        else if ((nmi_src & m_nmi) != 0) win = 14;
        else if (m_gie) begin
          for (int i = 13; i >= 0; i--)
            if (win < 0 && irq_req[i] && irq_en[i]) win = i;
        end
        m_vv = (win >= 0);
        if (win >= 0) begin
          m_slot = 4'(win);
          m_addr = 16'hFFE0 + 16'(2 * win);
          m_ack  = 16'(1) << win;
          if (win == 15) begin ng = 0; nn = '0; end
          else if (win == 14) nn = nn & ~(nmi_src & m_nmi);
          else ng = 0;
        end
      end
      if (fetch_valid && fetch_addr <= 16'h01FF) m_oor = 1;
      else if (win == 15) m_oor = 0;
      if (rstvec_valid && rstvec_data == 16'hFFFF) m_sleep = 1;
      m_gie = ng;
      m_nmi = nn;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] %s actual=%0h expected=%0h", req, scene, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R3/R13", "vec_valid", int'(vec_valid), int'(m_vv));
      chk("R3/R13", "vec_addr",  int'(vec_addr),  int'(m_addr));
      chk("R3/R13", "vec_slot",  int'(vec_slot),  int'(m_slot));
      chk("R7",     "ack",       int'(ack),       int'(m_ack));
      chk("R8",     "gie_q",     int'(gie_q),     int'(m_gie));
      chk("R9",     "nmi_en_q",  int'(nmi_en_q),  int'(m_nmi));
      chk("R11",    "oor_pend",  int'(oor_pend),  int'(m_oor));
      chk("R12",    "sleep_req", int'(sleep_req), int'(m_sleep));
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    accept = 0; gie_wr = 0; nmi_en_wr = 0; fetch_valid = 0; rstvec_valid = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 60000) begin @(posedge clk); cyc++; end
    fails++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 60000);
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst = 0;
    step();
    scene = "R1";
    chk("R1", "reset vec_addr", int'(vec_addr), 16'hFFFE);
    chk("R1", "reset vec_slot", int'(vec_slot), 15);
    chk("R1", "reset vec_valid", int'(vec_valid), 0);
    chk("R1", "reset gie", int'(gie_q), 0);

    // R2: pending qualified request without accept changes nothing
    scene = "R2";
    gie_wr = 1; gie_din = 1; step(); idle();
    irq_req[3] = 1; irq_en[3] = 1;
    repeat (3) step();
    chk("R2", "no accept valid", int'(vec_valid), 0);
    accept = 1; step(); idle();
    chk("R2", "accept slot", int'(vec_slot), 3);
    chk("R8", "gie cleared", int'(gie_q), 0);
    step();
    chk("R7", "ack one cycle", int'(ack), 0);

    // R6/R13: gie off, maskable pending, accept finds nothing
    scene = "R13";
    accept = 1; step(); idle();
    chk("R13", "no winner valid", int'(vec_valid), 0);
    chk("R13", "addr held", int'(vec_addr), 16'hFFE6);
    chk("R6", "gie gate ack", int'(ack), 0);

    // R3: several maskable pending, highest wins; then slot 0 alone
    scene = "R3";
    irq_req = 14'h2005; irq_en = 14'h3FFF;
    gie_wr = 1; gie_din = 1; step(); idle();
    accept = 1; step(); idle();
    chk("R3", "highest slot", int'(vec_slot), 13);
    chk("R3", "slot13 addr", int'(vec_addr), 16'hFFFA);
    irq_req = 14'h0001;
    gie_wr = 1; gie_din = 1; step(); idle();
    accept = 1; step(); idle();
    chk("R3", "slot0 addr", int'(vec_addr), 16'hFFE0);

    // R8: gie write in the same cycle as a maskable acceptance
    scene = "R8";
    gie_wr = 1; gie_din = 1; step(); idle();
    accept = 1; gie_wr = 1; gie_din = 1; step(); idle();
    chk("R8", "accept clear wins", int'(gie_q), 0);

    // R5/R9: non-maskable slot with gie off
    scene = "R5";
    irq_req = '0;
    nmi_en_wr = 1; nmi_en_din = 3'b111; step(); idle();
    nmi_src = 3'b010;
    accept = 1; step(); idle();
    chk("R5", "nmi slot", int'(vec_slot), 14);
    chk("R9", "nmi en bit cleared", int'(nmi_en_q), 3'b101);
    nmi_src = '0;

    // R11/R4/R10: out-of-range fetch bound and reset slot
    scene = "R11";
    fetch_valid = 1; fetch_addr = 16'h0200; step(); idle();
    chk("R11", "0200 no oor", int'(oor_pend), 0);
    fetch_valid = 1; fetch_addr = 16'h01FF; step(); idle();
    chk("R11", "01FF oor", int'(oor_pend), 1);
    scene = "R4";
    gie_wr = 1; gie_din = 1; step(); idle();
    nmi_src = 3'b001; irq_req[5] = 1;
    accept = 1; step(); idle();
    chk("R4", "reset slot", int'(vec_slot), 15);
    chk("R10", "gie cleared", int'(gie_q), 0);
    chk("R10", "nmi en cleared", int'(nmi_en_q), 0);
    chk("R10", "oor cleared", int'(oor_pend), 0);
    nmi_src = '0; irq_req = '0;

    // R12: erased reset vector
    scene = "R12";
    rstvec_valid = 1; rstvec_data = 16'h1234; step(); idle();
    chk("R12", "good vector", int'(sleep_req), 0);
    rstvec_valid = 1; rstvec_data = 16'hFFFF; step(); idle();
    repeat (2) step();
    chk("R12", "erased vector sticky", int'(sleep_req), 1);

    // Random mix checked against the model every cycle
    scene = "RAND";
    for (int n = 0; n < 3000; n++) begin
      accept      = ($urandom_range(0, 3) == 0);
      rst_src     = ($urandom_range(0, 30) == 0) ? 4'($urandom) : 4'h0;
      nmi_src     = ($urandom_range(0, 4) == 0) ? 3'($urandom) : 3'h0;
      nmi_en_wr   = ($urandom_range(0, 9) == 0);
      nmi_en_din  = 3'($urandom);
      irq_req     = 14'($urandom);
      irq_en      = 14'($urandom);
      gie_wr      = ($urandom_range(0, 3) == 0);
      gie_din     = 1'($urandom);
      fetch_valid = ($urandom_range(0, 1) == 0);
      fetch_addr  = ($urandom_range(0, 40) == 0) ? 16'($urandom_range(0, 16'h01FF))
                                                 : 16'($urandom_range(16'h0200, 16'hFFFF));
      rstvec_valid = ($urandom_range(0, 200) == 0);
      rstvec_data  = ($urandom_range(0, 1) == 0) ? 16'hFFFF : 16'($urandom);
      step();
    end
    idle();
    step();
    finish_run();
  end
endmodule